// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Command Controller

This block fronts a behavioural one-time-programmable fuse array and gives software a small word-addressed register port to drive it. Software first raises a power request and waits for the power-good flag. It then launches a fuse command with a single write to the command register. Three commands exist. A reload copies one fuse word into its shadow register. A program burns the bits held in the write-data register into a fuse word. A lock program burns the permanent-lock fuses that protect words from further programming.

Each fuse word has a shadow copy that software reads and writes directly. A direct write changes only the shadow, never the fuses. Per-word error and disturbed bits are gathered into 32-bit bank registers. A failed program marks the error bit of its word. A direct shadow write marks the disturbed bit of its word, and a later reload clears both bits again. A status register reports the busy flag, a sticky command-failure flag, power-good and a mode code. The busy, failure and power-good flags also appear on pins.

Top module: `otpc_top`

## Requirements
- R1: Bit 0 of the configuration register (offset 0x000) is the power request. Power-good (status bit 5, pin `pwr_good`) takes the request's new value exactly PWR_LAT cycles after the request changes. This holds for both power-up and power-down, and power-good never changes while it already equals the request.
- R2: A write to the command register (offset 0x004) carries the word index in bits 7:0 and the opcode in bits 9:8: 00 reload, 01 program, 11 lock program. Once accepted, busy (status bit 3, pin `busy`) rises on the next cycle and stays high for exactly READ_LAT cycles for a reload, or PROG_LAT cycles for a program or lock program.
- R3: When a reload of a word below N_WORDS completes, the shadow word takes the fuse contents and the word's error and disturbed bits are cleared.
- R4: A program ORs the captured write data (offset 0x008) into the fuse word, so a fuse bit never returns to 0. The program fails and leaves the word unchanged if the data has a 0 where the fuse already holds a 1, if the word is locked, or if the index is N_WORDS or above. A failure sets the word's error bit when the index is in range. A success clears that bit.
- R5: Shadow word i is at offset 0x200 + 4·i. A write there changes only the shadow and sets the word's disturbed bit. A later reload returns the unchanged fuse contents.
- R6: A command is ignored and the failure flag (status bit 4, pin `fail`) is set if it is written while power-good is low, while busy is high, or with opcode 10. A command that ends in failure also sets the flag. The next accepted command clears it.
- R7: Error bank b is at 0x010 + 4·b and disturbed bank b is at 0x030 + 4·b. Word i appears at bit i mod 32 of bank i/32.
- R8: A lock program ORs the captured write data into lock-fuse word a, where a is the index field. Lock word a reads back at 0x100 + 4·a. An index of LOCK_WORDS or above fails and changes nothing.
- R9: A word n below UPPER_BASE is locked when bit 2·(n mod 8) or bit 2·(n mod 8)+1 of lock word n/8 is set. A word n at or above UPPER_BASE is locked when bit n mod 16 of lock word UPPER_BASE/8 + (n − UPPER_BASE)/16 is set.
- R10: Status bits 2:0 read 1, 2 or 3 while a reload, program or lock program runs. They read 4 while the array is idle and power-good differs from the request, and 0 otherwise.
- R11: A read returns its data one cycle later with `bus_rvalid`. The configuration and write-data registers read back what was written, and the command register reads 0. After reset, all fuse, lock, shadow, bitmap and status contents read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| busy | output | 1 | A fuse command is running |
| fail | output | 1 | Sticky command-failure flag |
| pwr_good | output | 1 | Fuse array power is good |

## Verification
The bench uses N_WORDS=64 and UPPER_BASE=32, which gives two bitmap banks and six lock words. A single run therefore covers a bank crossing, both the paired-bit lock mapping for lower words and the single-bit mapping for upper words, and a lock index just past the last lock word. READ_LAT=8 and PROG_LAT=32 stay at their defaults so the two busy lengths are checked cycle by cycle. PWR_LAT is set to 5 so both power transitions and the mode-4 window stay short but still observable.

// File: rtl/otpc_pkg.sv
// Shared definitions of the fuse controller: opcodes, register offsets, mode codes.
// Assumes a 32-bit data path and byte addresses that are word aligned.
package otpc_pkg;

    typedef enum logic [1:0] {
        OP_RELOAD = 2'b00,
        OP_PROG   = 2'b01,
        OP_BAD    = 2'b10,
        OP_LOCK   = 2'b11
    } otp_op_e;

    localparam int OFF_CFG    = 'h000;
    localparam int OFF_CMD    = 'h004;
    localparam int OFF_WDATA  = 'h008;
    localparam int OFF_STAT   = 'h00C;
    localparam int OFF_ERR    = 'h010;
    localparam int OFF_DIST   = 'h030;
    localparam int OFF_LOCK   = 'h100;
    localparam int OFF_SHADOW = 'h200;

    localparam logic [2:0] MODE_IDLE   = 3'd0;
    localparam logic [2:0] MODE_RELOAD = 3'd1;
    localparam logic [2:0] MODE_PROG   = 3'd2;
    localparam logic [2:0] MODE_LOCK   = 3'd3;
    localparam logic [2:0] MODE_POWER  = 3'd4;

endpackage

// File: rtl/otpc_power_seq.sv
// Power sequencer of the fuse array: power-good follows the request after a fixed
// number of cycles, in both directions.
// Assumes PWR_LAT >= 1; a request that flips back before the delay restarts the count.
module otpc_power_seq #(
    parameter int PWR_LAT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic good,
    output logic in_transit
);
    localparam int PC_W = $clog2(PWR_LAT + 1);

    logic [PC_W-1:0] pcnt;

    // Count while request and power-good disagree; flip power-good at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            good <= 1'b0;
            pcnt <= '0;
        end else if (req != good) begin
            if (pcnt == PC_W'(PWR_LAT - 1)) begin
                good <= req;
                pcnt <= '0;
            end else begin
                pcnt <= pcnt + 1'b1;
            end
        end else begin
            pcnt <= '0;
        end
    end

    assign in_transit = (req != good);

    // R1
    power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == good) |=> $stable(good));

endmodule

// File: rtl/otpc_cmd_engine.sv
// Command engine: accepts or rejects a command write, captures it and holds busy
// for the opcode's latency, pulsing done in the last busy cycle.
// Assumes READ_LAT >= 1 and PROG_LAT >= 1.
module otpc_cmd_engine
    import otpc_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int READ_LAT = 8,
    parameter int PROG_LAT = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_go,
    input  otp_op_e          cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [31:0]      cmd_data,
    input  logic             pwr_ok,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             reject,
    output otp_op_e          cur_op,
    output logic [IDX_W-1:0] cur_idx,
    output logic [31:0]      cur_data
);
    localparam int LAT_MAX = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    logic [CNT_W-1:0] cnt;

    // Launch rule: powered, idle and a defined opcode.
    always_comb begin
        accept = cmd_go && !busy && pwr_ok && (cmd_op != OP_BAD);
        reject = cmd_go && !accept;
        done   = busy && (cnt == '0);
    end

    // Capture an accepted command and count down its latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cnt      <= '0;
            cur_op   <= OP_RELOAD;
            cur_idx  <= '0;
            cur_data <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            cnt      <= (cmd_op == OP_RELOAD) ? CNT_W'(READ_LAT - 1) : CNT_W'(PROG_LAT - 1);
            cur_op   <= cmd_op;
            cur_idx  <= cmd_idx;
            cur_data <= cmd_data;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    // R2
    launch_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);
    // R6
    idle_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && !busy) |=> !busy);
    // R2
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/otpc_fuse_model.sv
// Behavioural fuse array with its permanent-lock fuses. Judges a finishing command
// and applies it when it succeeds; fuse bits only ever go from 0 to 1.
// Assumes UPPER_BASE is a multiple of 8 and N_WORDS - UPPER_BASE a multiple of 16.
module otpc_fuse_model
    import otpc_pkg::*;
#(
    parameter int N_WORDS    = 64,
    parameter int UPPER_BASE = 32,
    parameter int IDX_W      = 8,
    parameter int LOCK_WORDS = 6,
    parameter int LA_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done,
    input  otp_op_e          op,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      data,
    input  logic [LA_W-1:0]  lk_sel,
    output logic [31:0]      lk_val,
    output logic [31:0]      fuse_word,
    output logic             in_range,
    output logic             op_fail
);
    localparam int WI_W = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
    localparam logic [IDX_W:0] N_LIM  = (IDX_W + 1)'(N_WORDS);
    localparam logic [IDX_W:0] LW_LIM = (IDX_W + 1)'(LOCK_WORDS);
    localparam logic [IDX_W-1:0] UB   = IDX_W'(UPPER_BASE);
    localparam logic [IDX_W-1:0] UB_LW = IDX_W'(UPPER_BASE / 8);

    logic [31:0] fuse_q [N_WORDS];
    logic [31:0] lock_q [LOCK_WORDS];

    logic [WI_W-1:0]  wi;
    logic [IDX_W-1:0] la_full;
    logic [LA_W-1:0]  la;
    logic [3:0]       bit_a;
    logic [3:0]       bit_b;
    logic             word_locked;
    logic             lock_in_range;
    logic [31:0]      lock_sel_word;

    // Find the lock fuses guarding the addressed word, by lower or upper mapping.
    always_comb begin
        wi            = idx[WI_W-1:0];
        in_range      = ({1'b0, idx} < N_LIM);
        lock_in_range = ({1'b0, idx} < LW_LIM);
        if (idx < UB) begin
            la_full = idx >> 3;
            bit_a   = {idx[2:0], 1'b0};
            bit_b   = {idx[2:0], 1'b1};
        end else begin
            la_full = UB_LW + ((idx - UB) >> 4);
            bit_a   = idx[3:0];
            bit_b   = idx[3:0];
        end
        la            = la_full[LA_W-1:0];
        lock_sel_word = ({1'b0, la_full} < LW_LIM) ? lock_q[la] : 32'h0;
        word_locked   = in_range && (lock_sel_word[bit_a] || lock_sel_word[bit_b]);
        fuse_word     = in_range ? fuse_q[wi] : 32'h0;
        lk_val        = ({1'b0, {(IDX_W - LA_W){1'b0}}, lk_sel} < LW_LIM) ? lock_q[lk_sel] : 32'h0;
    end

    // Decide whether the finishing command fails.
    always_comb begin
        unique case (op)
            OP_RELOAD: op_fail = !in_range;
            OP_PROG:   op_fail = !in_range || word_locked || ((fuse_word & ~data) != 32'h0);
            OP_LOCK:   op_fail = !lock_in_range;
            default:   op_fail = 1'b1;
        endcase
    end

    // Burn the fuse or lock word when a program command finishes without failure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++)    fuse_q[i] <= '0;
            for (int j = 0; j < LOCK_WORDS; j++) lock_q[j] <= '0;
        end else if (done && !op_fail) begin
            if (op == OP_PROG) fuse_q[wi] <= fuse_q[wi] | data;
            if (op == OP_LOCK) lock_q[idx[LA_W-1:0]] <= lock_q[idx[LA_W-1:0]] | data;
        end
    end

    // R4
    fuse_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_PROG && in_range) |=> ((fuse_word & $past(fuse_word)) == $past(fuse_word)));
    // R4
    fail_keeps_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op == OP_PROG && in_range && op_fail) |=> (fuse_word == $past(fuse_word)));

endmodule

// File: rtl/otpc_top.sv
// Fuse array command controller: register decode, shadow words, per-word error and
// disturbed bitmaps, status, and the power, command and fuse sub-blocks.
// Assumes word-aligned accesses and that the shadow region fits the address width.
module otpc_top
    import otpc_pkg::*;
#(
    parameter int N_WORDS    = 64,
    parameter int UPPER_BASE = 32,
    parameter int READ_LAT   = 8,
    parameter int PROG_LAT   = 32,
    parameter int PWR_LAT    = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        busy,
    output logic        fail,
    output logic        pwr_good
);
    localparam int ADDR_W     = 12;
    localparam int IDX_W      = 8;
    localparam int BANKS      = (N_WORDS + 31) / 32;
    localparam int BK_W       = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int LOCK_WORDS = UPPER_BASE / 8 + (N_WORDS - UPPER_BASE + 15) / 16;
    localparam int LA_W       = (LOCK_WORDS > 1) ? $clog2(LOCK_WORDS) : 1;
    localparam int WI_W       = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
    localparam logic [ADDR_W-1:0] A_CMD    = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_WDATA  = ADDR_W'(OFF_WDATA);
    localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_ERR    = ADDR_W'(OFF_ERR);
    localparam logic [ADDR_W-1:0] A_ERR_E  = ADDR_W'(OFF_ERR + 4 * BANKS);
    localparam logic [ADDR_W-1:0] A_DIST   = ADDR_W'(OFF_DIST);
    localparam logic [ADDR_W-1:0] A_DIST_E = ADDR_W'(OFF_DIST + 4 * BANKS);
    localparam logic [ADDR_W-1:0] A_LOCK   = ADDR_W'(OFF_LOCK);
    localparam logic [ADDR_W-1:0] A_LOCK_E = ADDR_W'(OFF_LOCK + 4 * LOCK_WORDS);
    localparam logic [ADDR_W-1:0] A_SH     = ADDR_W'(OFF_SHADOW);
    localparam logic [ADDR_W-1:0] A_SH_E   = ADDR_W'(OFF_SHADOW + 4 * N_WORDS);

    logic                 pwr_req;
    logic                 in_transit;
    logic [31:0]          wdata_q;
    logic                 fail_q;
    logic [31:0]          shadow [N_WORDS];
    logic [N_WORDS-1:0]   err_map;
    logic [N_WORDS-1:0]   dist_map;
    logic [BANKS*32-1:0]  err_pad;
    logic [BANKS*32-1:0]  dist_pad;
    logic [31:0]          err_bank  [BANKS];
    logic [31:0]          dist_bank [BANKS];

    logic                 wr_en, rd_en, aligned;
    logic                 cmd_go, shw_hit;
    logic                 err_hit, dist_hit, lock_hit, sh_hit;
    logic [ADDR_W-1:0]    err_off, dist_off, lock_off, sh_off;
    logic [BK_W-1:0]      err_b, dist_b;
    logic [LA_W-1:0]      lk_sel;
    logic [WI_W-1:0]      sh_i, cur_wi;
    logic [2:0]           mode;
    logic [31:0]          stat_word;
    logic [31:0]          rd_val;

    logic                 done, accept, reject;
    otp_op_e              cur_op;
    logic [IDX_W-1:0]     cur_idx;
    logic [31:0]          cur_data;
    logic [31:0]          lk_val, fuse_word;
    logic                 in_range, op_fail;

    otpc_power_seq #(.PWR_LAT(PWR_LAT)) power_i (
        .clk(clk), .rst_n(rst_n), .req(pwr_req), .good(pwr_good), .in_transit(in_transit)
    );

    otpc_cmd_engine #(.IDX_W(IDX_W), .READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)) engine_i (
        .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(otp_op_e'(bus_wdata[9:8])),
        .cmd_idx(bus_wdata[IDX_W-1:0]), .cmd_data(wdata_q), .pwr_ok(pwr_good),
        .busy(busy), .done(done), .accept(accept), .reject(reject),
        .cur_op(cur_op), .cur_idx(cur_idx), .cur_data(cur_data)
    );

    otpc_fuse_model #(.N_WORDS(N_WORDS), .UPPER_BASE(UPPER_BASE), .IDX_W(IDX_W),
                      .LOCK_WORDS(LOCK_WORDS), .LA_W(LA_W)) fuse_i (
        .clk(clk), .rst_n(rst_n), .done(done), .op(cur_op), .idx(cur_idx), .data(cur_data),
        .lk_sel(lk_sel), .lk_val(lk_val), .fuse_word(fuse_word),
        .in_range(in_range), .op_fail(op_fail)
    );

    // Split the flat bitmaps into 32-bit banks, zero-padded past the last word.
    always_comb begin
        err_pad  = '0;
        dist_pad = '0;
        err_pad[N_WORDS-1:0]  = err_map;
        dist_pad[N_WORDS-1:0] = dist_map;
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign err_bank[b]  = err_pad[b*32 +: 32];
        assign dist_bank[b] = dist_pad[b*32 +: 32];
    end

    // Decode the access into register hits and region indexes.
    always_comb begin
        aligned  = (bus_addr[1:0] == 2'b00);
        wr_en    = bus_valid && bus_write && aligned;
        rd_en    = bus_valid && !bus_write;
        cmd_go   = wr_en && (bus_addr == A_CMD);
        err_hit  = (bus_addr >= A_ERR)  && (bus_addr < A_ERR_E);
        dist_hit = (bus_addr >= A_DIST) && (bus_addr < A_DIST_E);
        lock_hit = (bus_addr >= A_LOCK) && (bus_addr < A_LOCK_E);
        sh_hit   = (bus_addr >= A_SH)   && (bus_addr < A_SH_E);
        err_off  = bus_addr - A_ERR;
        dist_off = bus_addr - A_DIST;
        lock_off = bus_addr - A_LOCK;
        sh_off   = bus_addr - A_SH;
        err_b    = err_off[BK_W+1:2];
        dist_b   = dist_off[BK_W+1:2];
        lk_sel   = lock_off[LA_W+1:2];
        sh_i     = sh_off[WI_W+1:2];
        shw_hit  = wr_en && sh_hit;
        cur_wi   = cur_idx[WI_W-1:0];
    end

    // Build the status word: mode code, busy, failure, power-good.
    always_comb begin
        if (busy) begin
            unique case (cur_op)
                OP_RELOAD: mode = MODE_RELOAD;
                OP_PROG:   mode = MODE_PROG;
                default:   mode = MODE_LOCK;
            endcase
        end else if (in_transit) begin
            mode = MODE_POWER;
        end else begin
            mode = MODE_IDLE;
        end
        stat_word = {26'h0, pwr_good, fail_q, busy, mode};
    end

    // Select the read value for the addressed register.
    always_comb begin
        rd_val = 32'h0;
        if (!aligned)                rd_val = 32'h0;
        else if (bus_addr == A_CFG)  rd_val = {31'h0, pwr_req};
        else if (bus_addr == A_WDATA) rd_val = wdata_q;
        else if (bus_addr == A_STAT) rd_val = stat_word;
        else if (err_hit)            rd_val = err_bank[err_b];
        else if (dist_hit)           rd_val = dist_bank[dist_b];
        else if (lock_hit)           rd_val = lk_val;
        else if (sh_hit)             rd_val = shadow[sh_i];
    end

    // Configuration and write-data registers, plus the sticky failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_req <= 1'b0;
            wdata_q <= '0;
            fail_q  <= 1'b0;
        end else begin
            if (wr_en && bus_addr == A_CFG)   pwr_req <= bus_wdata[0];
            if (wr_en && bus_addr == A_WDATA) wdata_q <= bus_wdata;
            if (accept)                            fail_q <= 1'b0;
            else if (reject || (done && op_fail))  fail_q <= 1'b1;
        end
    end

    // Shadow words and bitmaps: direct writes, then command results (results win).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_WORDS; i++) shadow[i] <= '0;
            err_map  <= '0;
            dist_map <= '0;
        end else begin
            if (shw_hit) begin
                shadow[sh_i]   <= bus_wdata;
                dist_map[sh_i] <= 1'b1;
            end
            if (done && in_range) begin
                if (cur_op == OP_RELOAD) begin
                    shadow[cur_wi]   <= fuse_word;
                    err_map[cur_wi]  <= 1'b0;
                    dist_map[cur_wi] <= 1'b0;
                end else if (cur_op == OP_PROG) begin
                    err_map[cur_wi]  <= op_fail;
                end
            end
        end
    end

    // Registered read return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= rd_en;
            if (rd_en) bus_rdata <= rd_val;
        end
    end

    assign fail = fail_q;

    // R6
    reject_sets_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> fail);
    // R5
    shadow_write_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shw_hit && !done) |=> dist_map[$past(sh_i)]);
    // R11
    read_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> bus_rvalid);
    // R6
    accept_clears_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !fail);

endmodule

// File: tb/otpc_tb.sv
// Bench: behavioural reference model updated each clock, compared each cycle on
// the flag pins and on every register read.
module otpc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 64;
    localparam int UBS = 32;
    localparam int RL  = 8;
    localparam int PL  = 32;
    localparam int PW  = 5;
    localparam int LW  = UBS / 8 + (NW - UBS + 15) / 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, busy, fail, pwr_good;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    otpc_top #(.N_WORDS(NW), .UPPER_BASE(UBS), .READ_LAT(RL), .PROG_LAT(PL), .PWR_LAT(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .busy(busy), .fail(fail), .pwr_good(pwr_good)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // reference model state
    logic [31:0] m_fuse [NW];
    logic [31:0] m_shadow [NW];
    logic [31:0] m_lock [LW];
    bit   m_err [NW];
    bit   m_dist [NW];
    bit   m_req, m_good, m_fail;
    int   m_pc, m_left, m_op, m_idx;
    logic [31:0] m_wd, m_cd;

    function automatic bit m_locked(int n);
        int w;
        if (n < UBS) begin
            w = n / 8;
            return m_lock[w][2 * (n % 8)] | m_lock[w][2 * (n % 8) + 1];
        end
        w = UBS / 8 + (n - UBS) / 16;
        return m_lock[w][n % 16];
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v = 32'h0;
        int md;
        if (a == 'h000) v = {31'h0, m_req};
        else if (a == 'h008) v = m_wd;
        else if (a == 'h00C) begin
            md = (m_left > 0) ? (m_op == 0 ? 1 : (m_op == 1 ? 2 : 3)) : (m_req != m_good ? 4 : 0);
            v = {26'h0, m_good, m_fail, (m_left > 0), 3'(md)};
        end else if (a >= 'h010 && a < 'h018) begin
            for (int k = 0; k < 32; k++) v[k] = m_err[(a - 'h010) / 4 * 32 + k];
        end else if (a >= 'h030 && a < 'h038) begin
            for (int k = 0; k < 32; k++) v[k] = m_dist[(a - 'h030) / 4 * 32 + k];
        end else if (a >= 'h100 && a < 'h100 + 4 * LW) v = m_lock[(a - 'h100) / 4];
        else if (a >= 'h200 && a < 'h200 + 4 * NW) v = m_shadow[(a - 'h200) / 4];
        return v;
    endfunction

    // Model update at each rising edge, from the inputs held since the falling edge.
    always @(posedge clk) begin
        bit bpre, gpre, rpre;
        int op;
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                m_fuse[i] = 0; m_shadow[i] = 0; m_err[i] = 0; m_dist[i] = 0;
            end
            for (int j = 0; j < LW; j++) m_lock[j] = 0;
            m_req = 0; m_good = 0; m_fail = 0; m_pc = 0; m_left = 0;
            m_op = 0; m_idx = 0; m_wd = 0; m_cd = 0;
        end else begin
            bpre = (m_left > 0); gpre = m_good; rpre = m_req;
            if (bus_valid && bus_write && bus_addr >= 'h200 && bus_addr < 'h200 + 4 * NW) begin
                m_shadow[(bus_addr - 'h200) / 4] = bus_wdata;
                m_dist[(bus_addr - 'h200) / 4] = 1;
            end
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) begin
                    if (m_op == 0) begin
                        if (m_idx < NW) begin
                            m_shadow[m_idx] = m_fuse[m_idx]; m_err[m_idx] = 0; m_dist[m_idx] = 0;
                        end else m_fail = 1;
                    end else if (m_op == 1) begin
                        if (m_idx >= NW) m_fail = 1;
                        else if (m_locked(m_idx) || ((m_fuse[m_idx] & ~m_cd) != 0)) begin
                            m_fail = 1; m_err[m_idx] = 1;
                        end else begin
                            m_fuse[m_idx] = m_fuse[m_idx] | m_cd; m_err[m_idx] = 0;
                        end
                    end else begin
                        if (m_idx >= LW) m_fail = 1;
                        else m_lock[m_idx] = m_lock[m_idx] | m_cd;
                    end
                end
            end
            if (rpre != gpre) begin
                if (m_pc == PW - 1) begin m_good = rpre; m_pc = 0; end
                else m_pc++;
            end else m_pc = 0;
            if (bus_valid && bus_write) begin
                if (bus_addr == 'h000) m_req = bus_wdata[0];
                if (bus_addr == 'h008) m_wd = bus_wdata;
                if (bus_addr == 'h004) begin
                    op = int'(bus_wdata[9:8]);
                    if (bpre || !gpre || op == 2) m_fail = 1;
                    else begin
                        m_fail = 0; m_op = (op == 3) ? 2 : op;
                        m_left = (op == 0) ? RL : PL;
                        m_idx = int'(bus_wdata[7:0]); m_cd = m_wd;
                    end
                end
            end
        end
    end

    // Per-cycle comparison of the flag pins against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks += 3;
            if (busy !== (m_left > 0)) begin
                failures++; $display("FAIL R2 busy got=%0b exp=%0b t=%0t", busy, m_left > 0, $time);
            end
            if (fail !== m_fail) begin
                failures++; $display("FAIL R6 fail got=%0b exp=%0b t=%0t", fail, m_fail, $time);
            end
            if (pwr_good !== m_good) begin
                failures++; $display("FAIL R1 pwr_good got=%0b exp=%0b t=%0t", pwr_good, m_good, $time);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a);
        @(posedge clk); @(negedge clk);
        bus_valid = 0;
        checks++;
        if (bus_rdata !== exp || bus_rvalid !== 1'b1) begin
            failures++;
            $display("FAIL %s addr=%h got=%h exp=%h rvalid=%0b", tag, a, bus_rdata, exp, bus_rvalid);
        end
    endtask

    task automatic rd_model(input int a, input string tag);
        rd_chk(a, m_read(a), tag);
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 200 && busy; n++) @(negedge clk);
    endtask

    task automatic cmd(input int op, input int idx, input logic [31:0] d);
        wr('h008, d);
        wr('h004, (op << 8) | idx);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: reset state
        rd_chk('h00C, 32'h0, "R11 status after reset");
        rd_chk('h010, 32'h0, "R11 error bank after reset");
        rd_chk('h200 + 4 * 7, 32'h0, "R11 shadow after reset");
        // R6: command while unpowered is ignored
        wr('h004, 32'h003);
        rd_chk('h00C, 32'h10, "R6 unpowered command rejected");
        // R1: power up, mode 4 during the transition
        wr('h000, 1);
        rd_chk('h00C, 32'h14, "R10 power transition mode");
        repeat (PW + 1) @(negedge clk);
        rd_chk('h00C, 32'h30, "R1 power good after delay");
        rd_chk('h000, 32'h1, "R11 config readback");
        // R4/R3: program word 3 then reload it
        cmd(1, 3, 32'h0000_00F0);
        rd_chk('h00C, 32'h2A, "R10 program mode while busy");
        wait_idle();
        rd_chk('h200 + 12, 32'h0, "R5 shadow untouched by program");
        wr('h004, 32'h003);
        rd_model('h00C, "R10 reload mode");
        wait_idle();
        rd_chk('h200 + 12, 32'h0000_00F0, "R3 reload shows programmed fuse");
        // R4: program that would clear a bit fails and flags the error bit
        cmd(1, 3, 32'h0000_000F);
        wait_idle();
        rd_chk('h010, 32'h0000_0008, "R7 error bit of word 3");
        rd_model('h00C, "R4 failure flag after clearing attempt");
        cmd(1, 3, 32'h0000_0FF0);
        wait_idle();
        rd_chk('h010, 32'h0, "R4 success clears error bit");
        wr('h004, 32'h003); wait_idle();
        rd_chk('h200 + 12, 32'h0000_0FF0, "R4 fuse is OR of programs");
        // R6: command while busy is ignored
        cmd(1, 9, 32'h1);
        wr('h004, 32'h00A);
        rd_model('h00C, "R6 busy command rejected");
        wait_idle();
        wr('h004, 32'h009); wait_idle();
        rd_chk('h200 + 36, 32'h1, "R6 busy-time command had no effect");
        wr('h004, 32'h203);
        rd_chk('h00C, 32'h30, "R6 opcode 10 rejected");
        // R5/R7: direct shadow write in bank 1
        wr('h200 + 4 * 40, 32'hDEAD_BEEF);
        rd_chk('h200 + 4 * 40, 32'hDEAD_BEEF, "R5 shadow direct write");
        rd_chk('h034, 32'h0000_0100, "R7 disturbed bank 1 bit 8");
        wr('h004, 32'h028); wait_idle();
        rd_chk('h200 + 4 * 40, 32'h0, "R5 fuse unchanged by shadow write");
        rd_chk('h034, 32'h0, "R3 reload clears disturbed bit");
        // R8/R9: lock lower word 5 with both bits, word 6 with one bit
        cmd(3, 0, 32'h0000_0C00); wait_idle();
        cmd(3, 0, 32'h0000_2000); wait_idle();
        rd_chk('h100, 32'h0000_2C00, "R8 lock word readback");
        cmd(1, 5, 32'h1); wait_idle();
        rd_chk('h010, 32'h0000_0020, "R9 lower word 5 locked");
        cmd(1, 6, 32'h1); wait_idle();
        rd_chk('h010, 32'h0000_0060, "R9 lower word 6 locked by one bit");
        cmd(1, 4, 32'h1); wait_idle();
        rd_model('h010, "R9 neighbour word 4 still programmable");
        // R9: upper word 50 uses lock word 5 bit 2
        cmd(3, 5, 32'h0000_0004); wait_idle();
        cmd(1, 50, 32'h1); wait_idle();
        rd_chk('h014, 32'h0004_0000, "R9 upper word 50 locked");
        cmd(1, 49, 32'h1); wait_idle();
        rd_model('h014, "R9 upper word 49 unaffected");
        // R8/R4: out-of-range lock address and word index
        cmd(3, LW, 32'hFF); wait_idle();
        rd_chk('h00C, 32'h30, "R8 lock index past last word fails");
        cmd(1, 70, 32'h1); wait_idle();
        rd_model('h00C, "R4 program index out of range fails");
        rd_chk('h004, 32'h0, "R11 command register reads zero");
        rd_chk('h008, 32'h1, "R11 write-data readback");
        // R1: power down
        wr('h000, 0);
        rd_chk('h00C, 32'h34, "R10 power-down transition mode");
        repeat (PW + 1) @(negedge clk);
        rd_model('h00C, "R1 power good drops after delay");
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule